// File: doc/BRIEF.md
# Masked Local-Bus Interrupt Controller

This block collects a set of level-sensitive interrupt request lines into a registered source vector. An enable mask, held in a register that software can write, is combined by bitwise AND with the source vector. Any bit that survives the mask raises a single combined interrupt output toward the processor.

Software reads a small 16-bit register window with two locations. The vector location returns an encoded value that identifies the lowest-numbered pending line, so a handler can dispatch without scanning a bitmap. The mask location reads back, and loads, the enable mask. Pending state is not latched: it follows the input levels one clock behind. Nothing has to be acknowledged.

Top module: `intc_local`

## Requirements
- R1: On every rising clock edge, source bit i takes the level of input line i, so a rise or fall on a line shows in the source register after that edge.
- R2: `irq_out` is high exactly when the AND of the source register and the enable mask is non-zero. It follows the registered state with no further delay, so it changes right after the edge that updates either register.
- R3: Reading address 0 returns (i+1)*4, where i is the lowest-numbered pending bit. With 16 lines, line 0 reads 4 and line 15 reads 64.
- R4: Reading address 0 returns 0 when no bit is pending.
- R5: After reset the source register is all zeros, the enable mask is 0x0010 (only line 4 enabled) and `irq_out` is low.
- R6: A write to address 1 loads `reg_wdata` into the enable mask at that clock edge. Reading address 1 returns the mask, zero-extended to 16 bits.
- R7: A write to address 0 is ignored. The mask keeps its value and the source register keeps following the inputs.
- R8: An active line whose mask bit is clear changes neither the vector read nor `irq_out`, even when it has a lower number than an enabled active line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | 16 | Level-sensitive interrupt request lines |
| reg_addr | input | 1 | Register select: 0 = encoded vector, 1 = enable mask |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register (combinational) |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
The assertions assume that the request lines, the write strobe, the select and the write data are synchronous and stable around each rising edge. They also assume that the mask changes only through a write to address 1. The stimulus meets this by driving every input on the falling edge. The random phase draws line patterns that are sparse, single-bit or all-ones, and mixes writes to both addresses. This covers the lowest-index priority, fully masked sources and ignored writes while every input stays within those rules.

// File: rtl/intc_pkg.sv
package intc_pkg;
   typedef enum logic {
      REG_VEC  = 1'b0,
      REG_MASK = 1'b1
   } intc_reg_e;

   localparam int unsigned VEC_SHIFT = 2;
endpackage

// File: rtl/intc_src_cap.sv
module intc_src_cap #(
   parameter int unsigned NUM_SRC = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] lines,
   output logic [NUM_SRC-1:0] src_q
);
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) src_q[g] <= 1'b0;
         else        src_q[g] <= lines[g];
      end
   end

   p_src_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> src_q == $past(lines));
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
   parameter int unsigned           NUM_SRC  = 16,
   parameter logic [NUM_SRC-1:0]    MASK_RST = NUM_SRC'(16'h0010)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [NUM_SRC-1:0] d,
   output logic [NUM_SRC-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= MASK_RST;
      else if (load) q <= d;
   end

   p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> q == $past(d));
   p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));
endmodule

// File: rtl/intc_lowest_enc.sv
module intc_lowest_enc #(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned VEC_W   = 16
) (
   input  logic [NUM_SRC-1:0] pend,
   output logic [VEC_W-1:0]   vec,
   output logic               any
);
   import intc_pkg::*;

   always_comb begin
      vec = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pend[i]) vec = VEC_W'((i + 1) << VEC_SHIFT);
      end
   end

   assign any = |pend;
endmodule

// File: rtl/intc_local.sv
module intc_local #(
   parameter int unsigned        NUM_SRC  = 16,
   parameter int unsigned        DATA_W   = 16,
   parameter logic [NUM_SRC-1:0] MASK_RST = NUM_SRC'(16'h0010)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_lines,
   input  logic               reg_addr,
   input  logic               reg_wr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               irq_out
);
   import intc_pkg::*;

   localparam int unsigned VEC_W = $clog2(NUM_SRC + 1) + VEC_SHIFT;

   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("NUM_SRC must lie in 1..DATA_W");
   end
   if (VEC_W > DATA_W) begin : g_bad_vec
      $error("DATA_W too narrow for encoded vector");
   end

   intc_reg_e           sel;
   logic [NUM_SRC-1:0]  src_q;
   logic [NUM_SRC-1:0]  mask_q;
   logic [NUM_SRC-1:0]  pending;
   logic [VEC_W-1:0]    vec_w;
   logic                any_w;
   logic                mask_load;
   logic [DATA_W-1:0]   mask_rd;
   logic [DATA_W-1:0]   vec_rd;

   assign sel       = intc_reg_e'(reg_addr);
   assign mask_load = reg_wr && (sel == REG_MASK);

   intc_src_cap #(.NUM_SRC(NUM_SRC)) i_src (
      .clk   (clk),
      .rst_n (rst_n),
      .lines (irq_lines),
      .src_q (src_q)
   );

   intc_mask_reg #(.NUM_SRC(NUM_SRC), .MASK_RST(MASK_RST)) i_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (mask_load),
      .d     (reg_wdata[NUM_SRC-1:0]),
      .q     (mask_q)
   );

   assign pending = src_q & mask_q;

   intc_lowest_enc #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) i_enc (
      .pend (pending),
      .vec  (vec_w),
      .any  (any_w)
   );

   if (NUM_SRC < DATA_W) begin : g_mask_ext
      assign mask_rd = {{(DATA_W-NUM_SRC){1'b0}}, mask_q};
   end else begin : g_mask_full
      assign mask_rd = mask_q;
   end

   if (VEC_W < DATA_W) begin : g_vec_ext
      assign vec_rd = {{(DATA_W-VEC_W){1'b0}}, vec_w};
   end else begin : g_vec_full
      assign vec_rd = vec_w;
   end

   assign reg_rdata = (sel == REG_MASK) ? mask_rd : vec_rd;
   assign irq_out   = any_w;

   // checker view of the encoded vector
   int                 chk_pos;
   logic [NUM_SRC-1:0] chk_below;
   always_comb begin
      chk_pos   = int'(vec_w >> VEC_SHIFT) - 1;
      chk_below = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (i < chk_pos) chk_below[i] = 1'b1;
      end
   end

   p_vec_zero_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_w == '0) == !irq_out);
   p_vec_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (chk_pos >= 0 && chk_pos < NUM_SRC &&
                   pending[chk_pos] && (pending & chk_below) == '0));
   p_out_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q & src_q) == '0 |-> !irq_out);
endmodule

// File: tb/test_intc_local.sv
module test_intc_local;
   localparam int N = 16;
   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_lines = '0;
   logic          reg_addr = 1'b0;
   logic          reg_wr = 1'b0;
   logic [W-1:0]  reg_wdata = '0;
   logic [W-1:0]  reg_rdata;
   logic          irq_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [N-1:0] m_src  = '0;
   logic [N-1:0] m_mask = 16'h0010;

   always #5 clk = ~clk;

   intc_local i_intc_local (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_out(irq_out)
   );

   function automatic logic [W-1:0] exp_vec(logic [N-1:0] p);
      for (int i = 0; i < N; i++) if (p[i]) return W'((i + 1) * 4);
      return '0;
   endfunction

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic verify(string req);
      reg_wr = 1'b0;
      reg_addr = 1'b0; #1;
      chk({req, " vector"}, reg_rdata, exp_vec(m_src & m_mask));
      chk({req, " irq_out"}, W'(irq_out), W'(|(m_src & m_mask)));
      reg_addr = 1'b1; #1;
      chk({req, " mask"}, reg_rdata, W'(m_mask));
   endtask

   task automatic step(logic [N-1:0] lines, logic wr, logic addr,
                       logic [W-1:0] wd, string req);
      @(negedge clk);
      irq_lines = lines; reg_wr = wr; reg_addr = addr; reg_wdata = wd;
      @(posedge clk); #1;
      m_src = lines;
      if (wr && addr) m_mask = wd[N-1:0];
      verify(req);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int unused = $urandom(32'd1234);
      repeat (3) @(posedge clk);
      #1;
      verify("R5 reset");
      @(negedge clk); rst_n = 1'b1;

      step(16'h0010, 0, 0, 0, "R1 R2 line4");              // vector 20
      step(16'h0008, 0, 0, 0, "R8 masked line3");          // vector 0
      step(16'h0018, 0, 0, 0, "R8 lower masked");          // vector 20
      step(16'h0000, 0, 0, 0, "R4 none pending");
      step(16'h8008, 1, 1, 16'hFFFF, "R6 mask all");
      step(16'h8008, 0, 0, 0, "R3 lowest of two");         // 16
      step(16'h8000, 0, 0, 0, "R3 top line");              // 64
      step(16'h0001, 0, 0, 0, "R3 line0");                 // 4
      step(16'h0001, 1, 0, 16'h0000, "R7 write to vector ignored");
      step(16'h0001, 1, 1, 16'h0000, "R6 mask clear");
      step(16'hFFFF, 0, 0, 0, "R2 all masked");

      for (int k = 0; k < 400; k++) begin
         logic [N-1:0] l;
         logic [W-1:0] d;
         int kind = $urandom_range(0, 3);
         case (kind)
            0: l = N'(1) << $urandom_range(0, N - 1);
            1: l = N'($urandom) & N'($urandom) & N'($urandom);
            2: l = '1;
            default: l = N'($urandom);
         endcase
         d = W'($urandom);
         step(l, ($urandom_range(0, 2) == 0), $urandom_range(0, 1) == 1, d,
              "R1 R2 R3 R6 R7 random");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule